// File: doc/BRIEF.md
# Two-Way Latched/Registered Bus Transceiver

This block moves a data word between two buses, A and B, in either direction. Each direction has its own storage stage and its own set of four controls: a drive-enable, a transparency control, a capture strobe and a strobe gate. Data passes through without inversion.

When a direction's transparency control is high, that direction's output follows its input within the same cycle. When the control is low, the storage stage holds its word, and loads a new one only when its capture strobe rises while the strobe gate is asserted. The capture strobe is an ordinary data-rate signal. It is sampled on the system clock, and its low-to-high change is detected there.

Outputs that could float are modelled as a data vector plus a per-bit drive-enable vector. This lets a pad ring or bus fabric elsewhere in the chip implement the high-impedance state. The drive-enable has no effect on storage, so a direction keeps loading data while its outputs are released.

Top module: `bus_xcvr`

## Requirements
- R1: The data path is BUS_W bits wide (default 18) and non-inverting. With transparency on, the pattern 18'h2AAAA on one bus appears unchanged on the other bus.
- R2: While a direction's transparency control (le_ab / le_ba) is 1, that direction's output data equals its input data in the same cycle.
- R3: While transparency is 0 and no rising capture strobe is detected at a clock edge, the stored word and the output remain unchanged.
- R4: A rising capture strobe is a clock edge where the strobe is 1 and was 0 at the previous clock edge. When transparency is 0, the strobe gate (ce_ab_n / ce_ba_n) is 0 and a rising strobe is detected, the input is stored at that edge and appears at the output right after it.
- R5: When the strobe gate is 1, a rising capture strobe leaves the stored word unchanged.
- R6: A drive-enable input (oe_ab_n / oe_ba_n) of 0 sets every bit of that bus's drive vector to 1, and a value of 1 clears every bit. The drive-enable never affects the stored word or the output data.
- R7: The B-to-A direction follows R2 to R5 using only its own controls, independently of the A-to-B direction.
- R8: While rst_n is 0, both stored words and both strobe histories are zero. With transparency off, both output words therefore read zero.
- R9: When transparency drops from 1 to 0 and no capture occurs, the output holds the input value sampled at the last clock edge that had transparency on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | BUS_W | Data received from bus A |
| b_in | input | BUS_W | Data received from bus B |
| oe_ab_n | input | 1 | Drive-enable toward bus B, active low |
| le_ab | input | 1 | Transparency control, A to B |
| cp_ab | input | 1 | Capture strobe, A to B |
| ce_ab_n | input | 1 | Strobe gate, A to B, active low |
| oe_ba_n | input | 1 | Drive-enable toward bus A, active low |
| le_ba | input | 1 | Transparency control, B to A |
| cp_ba | input | 1 | Capture strobe, B to A |
| ce_ba_n | input | 1 | Strobe gate, B to A, active low |
| b_out | output | BUS_W | Data driven onto bus B |
| b_drv | output | BUS_W | Per-bit drive enable for bus B |
| a_out | output | BUS_W | Data driven onto bus A |
| a_drv | output | BUS_W | Per-bit drive enable for bus A |

## Verification
A corrupted stored word stays hidden while transparency is on. It shows on the output in the first cycle that transparency is off, and stays visible until the next capture overwrites it. A wrong strobe history shows one clock after the missed or extra rising strobe, as a load that should not happen or as a lost load. Comparing every output against a reference model on every cycle bounds detection to one clock after the first cycle in which the error can be observed.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;
  parameter int unsigned BUS_W_DEF = 18;
  parameter int unsigned N_DIR     = 2;
  typedef enum logic [0:0] {DIR_AB = 1'b0, DIR_BA = 1'b1} dir_e;
endpackage

// File: rtl/xcvr_edge_det.sv
module xcvr_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;
  logic lvl_d;

  always_comb begin
    lvl_d = lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_d;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         le,
  input  logic         cp,
  input  logic         ce_n,
  output logic [W-1:0] dout
);
  logic         rise;
  logic         load;
  logic [W-1:0] q_r;
  logic [W-1:0] q_nx;

  xcvr_edge_det u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (cp),
    .rise (rise)
  );

  // transparency wins over any strobe edge
  always_comb begin
    load = le | (rise & ~ce_n);
    q_nx = load ? din : q_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nx;
  end

  assign dout = le ? din : q_r;

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && !rise) |=> (le || $stable(dout)));

  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && rise && !ce_n) |=> (le || dout == $past(din)));

  p_gate_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && rise && ce_n) |=> (le || $stable(dout)));

  p_latch_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
    le |=> (le || dout == $past(din)));
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr
  import bus_xcvr_pkg::*;
#(
  parameter int unsigned BUS_W = BUS_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] a_in,
  input  logic [BUS_W-1:0] b_in,
  input  logic             oe_ab_n,
  input  logic             le_ab,
  input  logic             cp_ab,
  input  logic             ce_ab_n,
  input  logic             oe_ba_n,
  input  logic             le_ba,
  input  logic             cp_ba,
  input  logic             ce_ba_n,
  output logic [BUS_W-1:0] b_out,
  output logic [BUS_W-1:0] b_drv,
  output logic [BUS_W-1:0] a_out,
  output logic [BUS_W-1:0] a_drv
);
  logic [N_DIR-1:0][BUS_W-1:0] din_v;
  logic [N_DIR-1:0][BUS_W-1:0] dout_v;
  logic [N_DIR-1:0][BUS_W-1:0] drv_v;
  logic [N_DIR-1:0]            oe_n_v;
  logic [N_DIR-1:0]            le_v;
  logic [N_DIR-1:0]            cp_v;
  logic [N_DIR-1:0]            ce_n_v;

  assign din_v[DIR_AB]  = a_in;
  assign din_v[DIR_BA]  = b_in;
  assign oe_n_v[DIR_AB] = oe_ab_n;
  assign oe_n_v[DIR_BA] = oe_ba_n;
  assign le_v[DIR_AB]   = le_ab;
  assign le_v[DIR_BA]   = le_ba;
  assign cp_v[DIR_AB]   = cp_ab;
  assign cp_v[DIR_BA]   = cp_ba;
  assign ce_n_v[DIR_AB] = ce_ab_n;
  assign ce_n_v[DIR_BA] = ce_ba_n;

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    xcvr_lane #(.W(BUS_W)) u_lane (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (din_v[d]),
      .le   (le_v[d]),
      .cp   (cp_v[d]),
      .ce_n (ce_n_v[d]),
      .dout (dout_v[d])
    );
    assign drv_v[d] = {BUS_W{~oe_n_v[d]}};
  end

  assign b_out = dout_v[DIR_AB];
  assign b_drv = drv_v[DIR_AB];
  assign a_out = dout_v[DIR_BA];
  assign a_drv = drv_v[DIR_BA];

  p_drive_uniform_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(b_drv) == 0 || $countones(b_drv) == BUS_W) &&
    ($countones(a_drv) == 0 || $countones(a_drv) == BUS_W));
endmodule

// File: tb/tb_bus_xcvr.sv
`timescale 1ns/1ps
module tb_bus_xcvr;
  localparam int W = 18;
  localparam logic [W-1:0] ONES = '1;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] a_in, b_in, b_out, b_drv, a_out, a_drv;
  logic oe_ab_n, le_ab, cp_ab, ce_ab_n, oe_ba_n, le_ba, cp_ba, ce_ba_n;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  // behavioural reference state
  logic [W-1:0] m_q [2];
  logic         m_cp [2];
  string        m_tag [2];

  always #2 clk = ~clk;

  bus_xcvr dut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .oe_ab_n(oe_ab_n), .le_ab(le_ab), .cp_ab(cp_ab), .ce_ab_n(ce_ab_n),
    .oe_ba_n(oe_ba_n), .le_ba(le_ba), .cp_ba(cp_ba), .ce_ba_n(ce_ba_n),
    .b_out(b_out), .b_drv(b_drv), .a_out(a_out), .a_drv(a_drv)
  );

  function automatic void mstep(int d, logic [W-1:0] din, logic le, logic cp, logic ce_n);
    bit edge_seen;
    edge_seen = cp && !m_cp[d];
    if (le) begin
      m_q[d] = din; m_tag[d] = "R2";
    end else if (edge_seen && !ce_n) begin
      m_q[d] = din; m_tag[d] = "R4";
    end else if (edge_seen) begin
      m_tag[d] = "R5";
    end else begin
      m_tag[d] = "R3";
    end
    m_cp[d] = cp;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < 2; d++) begin
        m_q[d] = '0; m_cp[d] = 1'b0; m_tag[d] = "R8";
      end
    end else begin
      mstep(0, a_in, le_ab, cp_ab, ce_ab_n);
      mstep(1, b_in, le_ba, cp_ba, ce_ba_n);
    end
  end

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk({m_tag[0], " a->b data"}, b_out, le_ab ? a_in : m_q[0]);
    chk({"R7 ", m_tag[1], " b->a data"}, a_out, le_ba ? b_in : m_q[1]);
    chk("R6 b drive", b_drv, oe_ab_n ? '0 : ONES);
    chk("R6 a drive", a_drv, oe_ba_n ? '0 : ONES);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [W-1:0] held;
    rst_n = 1'b0;
    a_in = 18'h3FFFF; b_in = 18'h12345;
    oe_ab_n = 1'b1; le_ab = 1'b0; cp_ab = 1'b1; ce_ab_n = 1'b0;
    oe_ba_n = 1'b1; le_ba = 1'b0; cp_ba = 1'b1; ce_ba_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 b_out in reset", b_out, '0);
    chk("R8 a_out in reset", a_out, '0);
    chk("R6 b_drv off", b_drv, '0);
    rst_n = 1'b1;
    // R8: strobe history is zero, so cp high at first edge is a rise
    step();
    chk("R8 rise after reset", b_out, 18'h3FFFF);

    // R1 non-inverting transparent path
    oe_ab_n = 1'b0; le_ab = 1'b1; cp_ab = 1'b0; a_in = 18'h2AAAA;
    #0.5;
    chk("R1 pattern b_out", b_out, 18'h2AAAA);
    chk("R6 b_drv on", b_drv, ONES);
    step();

    // R9 latch closes on last sampled value
    a_in = 18'h0F0F0; step();
    held = 18'h0F0F0;
    le_ab = 1'b0; a_in = 18'h11111; step();
    chk("R9 hold after close", b_out, held);
    step();
    chk("R3 hold steady", b_out, held);

    // R5 gated strobe ignored while outputs released (R6)
    oe_ab_n = 1'b1; ce_ab_n = 1'b1; cp_ab = 1'b1; step();
    chk("R5 gated edge", b_out, held);
    ce_ab_n = 1'b0; cp_ab = 1'b0; step();
    cp_ab = 1'b1; a_in = 18'h22222; step();
    chk("R4 capture while released R6", b_out, 18'h22222);

    // R7 independence: strobe B->A only
    le_ba = 1'b0; cp_ba = 1'b0; step();
    b_in = 18'h0ABCD; cp_ba = 1'b1; a_in = 18'h33333; step();
    chk("R7 b->a captured", a_out, 18'h0ABCD);
    chk("R7 a->b untouched", b_out, 18'h22222);

    // randomized stretch
    for (int i = 0; i < 3000; i++) begin
      a_in = W'($urandom); b_in = W'($urandom);
      le_ab = ($urandom % 5) == 0; le_ba = ($urandom % 5) == 0;
      cp_ab = $urandom % 2; cp_ba = $urandom % 2;
      ce_ab_n = ($urandom % 4) == 0; ce_ba_n = ($urandom % 4) == 0;
      oe_ab_n = $urandom % 2; oe_ba_n = $urandom % 2;
      step();
    end
    finish_run();
  end
endmodule